// File: doc/BRIEF.md
# Serial DDS Programming Controller

This block is a hardware master that loads a direct digital synthesizer through its three-wire serial port. A client gives it a finished 32-bit frequency tuning word, a flag that turns on the synthesizer's x6 reference multiplier, and a 5-bit phase step in units of 11.25 degrees. These arrive on a valid/ready request interface. The block then drives a data line, a word clock and a frequency-update strobe.

After reset, before it takes any request, the controller runs a fixed handshake that puts the synthesizer into serial load mode: one word-clock pulse with data held low, then one update-strobe pulse. Each later request turns into a 40-bit frame. The frame holds the tuning word and then a control byte, both least significant bit first. One update-strobe pulse follows the frame. A parameter sets how many system clocks each signalling phase lasts, so the serial rate can be matched to the board.

Top module: `dds_serial_loader`

## Requirements
- R1: After reset, ready stays low while the controller gives exactly one word-clock pulse with data low and then one update-strobe pulse. Ready rises only after that.
- R2: Each accepted request produces exactly 40 word-clock pulses followed by exactly one update-strobe pulse.
- R3: The frame carries tuning-word bits 0 through 31 in that order, then control-byte bits 0 through 7 in that order. The bit on the data line at the n-th rising word-clock edge is frame bit n-1.
- R4: Data is set while the word clock is low. It does not change at the rising edge, and it holds until the word clock has fallen.
- R5: Control-byte bit 0 is the multiplier enable. Bits 2:1 are zero. Bits 7:3 are the 5-bit phase step, unsigned.
- R6: The update strobe is never high while the word clock is high. It rises only after the 40th word-clock pulse has ended.
- R7: Every data-setup phase, word-clock high phase, word-clock low phase, strobe high phase and strobe low phase lasts PHASE_CYC system clocks (default 2).
- R8: Ready goes low in the cycle after a request is accepted. It stays low until the update strobe has fallen. A request held valid during that time is accepted afterwards, not dropped.
- R9: While ready is high, data, word clock and strobe are all low.
- R10: The word, multiplier and phase fields are captured when the request is accepted. Changing these inputs during a load does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_word | input | 32 | Frequency tuning word |
| req_mult | input | 1 | x6 reference multiplier enable |
| req_phase | input | 5 | Phase offset in 11.25-degree steps |
| dds_data | output | 1 | Serial data to the synthesizer |
| dds_wclk | output | 1 | Serial word clock |
| dds_fqud | output | 1 | Frequency-update strobe |

## Verification
The properties assume that the client obeys the valid/ready rule: a request counts only in a cycle where ready is high. They also assume that reset is held long enough for the phase counter and the frame counter to start from zero. Apart from that, they treat the request inputs as unconstrained. The stimulus raises valid only on a falling clock edge and lowers it one full cycle after it has seen ready. One scenario keeps valid high on purpose and changes the request fields while a load runs, so the capture and hold-off rules are exercised without breaking the interface rule.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

    localparam int TW_W    = 32;
    localparam int PH_W    = 5;
    localparam int CTL_W   = 8;
    localparam int PAD_W   = CTL_W - PH_W - 1;
    localparam int FRAME_W = TW_W + CTL_W;

    typedef struct packed {
        logic [TW_W-1:0] word;
        logic            mult;
        logic [PH_W-1:0] phase;
    } dds_req_t;

    typedef enum logic [3:0] {
        ST_ENT_SETUP,
        ST_ENT_HI,
        ST_ENT_LO,
        ST_ENT_STB,
        ST_ENT_GAP,
        ST_IDLE,
        ST_BIT_SETUP,
        ST_BIT_HI,
        ST_BIT_LO,
        ST_STB_HI,
        ST_STB_LO
    } seq_state_e;

    function automatic logic [CTL_W-1:0] pack_ctl(input logic mult,
                                                  input logic [PH_W-1:0] ph);
        return {ph, {PAD_W{1'b0}}, mult};
    endfunction

    function automatic logic [FRAME_W-1:0] pack_frame(input dds_req_t r);
        return {pack_ctl(r.mult, r.phase), r.word};
    endfunction

    function automatic logic is_bit_state(input seq_state_e s);
        return (s == ST_BIT_SETUP) || (s == ST_BIT_HI) || (s == ST_BIT_LO);
    endfunction

endpackage

// File: rtl/dds_ldr_tick.sv
module dds_ldr_tick #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);
    generate
        if (PHASE_CYC <= 1) begin : g_single
            assign phase_end = run;
        end else begin : g_count
            localparam int CW = $clog2(PHASE_CYC);
            localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !run || phase_end) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign phase_end = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/dds_ldr_shift.sv
module dds_ldr_shift
    import dds_ldr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic               advance,
    output logic               ser_bit,
    output logic               last_bit
);
    localparam int BCW = $clog2(FRAME_W);
    localparam logic [BCW-1:0] LAST_IDX = BCW'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [BCW-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            frame_q <= load_frame;
            idx_q   <= '0;
        end else if (advance) begin
            frame_q <= {1'b0, frame_q[FRAME_W-1:1]};
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign ser_bit  = frame_q[0];
    assign last_bit = (idx_q == LAST_IDX);
endmodule

// File: rtl/dds_ldr_seq.sv
module dds_ldr_seq
    import dds_ldr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic phase_end,
    input  logic last_bit,
    input  logic ser_bit,
    output logic run,
    output logic ready,
    output logic load,
    output logic advance,
    output logic dds_data,
    output logic dds_wclk,
    output logic dds_fqud
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ENT_SETUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_ENT_SETUP: if (phase_end) state_d = ST_ENT_HI;
            ST_ENT_HI:    if (phase_end) state_d = ST_ENT_LO;
            ST_ENT_LO:    if (phase_end) state_d = ST_ENT_STB;
            ST_ENT_STB:   if (phase_end) state_d = ST_ENT_GAP;
            ST_ENT_GAP:   if (phase_end) state_d = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    load    = 1'b1;
                    state_d = ST_BIT_SETUP;
                end
            end
            ST_BIT_SETUP: if (phase_end) state_d = ST_BIT_HI;
            ST_BIT_HI:    if (phase_end) state_d = ST_BIT_LO;
            ST_BIT_LO: begin
                if (phase_end) begin
                    if (last_bit) begin
                        state_d = ST_STB_HI;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_BIT_SETUP;
                    end
                end
            end
            ST_STB_HI:    if (phase_end) state_d = ST_STB_LO;
            ST_STB_LO:    if (phase_end) state_d = ST_IDLE;
            default:      state_d = ST_ENT_SETUP;
        endcase
    end

    assign run      = (state_q != ST_IDLE);
    assign ready    = (state_q == ST_IDLE);
    assign dds_wclk = (state_q == ST_ENT_HI) || (state_q == ST_BIT_HI);
    assign dds_fqud = (state_q == ST_ENT_STB) || (state_q == ST_STB_HI);
    assign dds_data = is_bit_state(state_q) ? ser_bit : 1'b0;
endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
    import dds_ldr_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [TW_W-1:0] req_word,
    input  logic            req_mult,
    input  logic [PH_W-1:0] req_phase,
    output logic            dds_data,
    output logic            dds_wclk,
    output logic            dds_fqud
);
    dds_req_t           req;
    logic [FRAME_W-1:0] frame;
    logic               run, phase_end, load, advance, ser_bit, last_bit;

    assign req.word  = req_word;
    assign req.mult  = req_mult;
    assign req.phase = req_phase;
    assign frame     = pack_frame(req);

    dds_ldr_tick #(.PHASE_CYC(PHASE_CYC)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .phase_end (phase_end)
    );

    dds_ldr_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_frame (frame),
        .advance    (advance),
        .ser_bit    (ser_bit),
        .last_bit   (last_bit)
    );

    dds_ldr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .phase_end (phase_end),
        .last_bit  (last_bit),
        .ser_bit   (ser_bit),
        .run       (run),
        .ready     (req_ready),
        .load      (load),
        .advance   (advance),
        .dds_data  (dds_data),
        .dds_wclk  (dds_wclk),
        .dds_fqud  (dds_fqud)
    );
endmodule

// File: rtl/dds_serial_loader_chk.sv
module dds_serial_loader_chk
    import dds_ldr_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic dds_data,
    input logic dds_wclk,
    input logic dds_fqud
);
    int unsigned hi_cnt, stb_cnt;
    logic [7:0]  bits_since;
    logic        seen_req, wclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= 0;
            stb_cnt    <= 0;
            bits_since <= '0;
            seen_req   <= 1'b0;
            wclk_q     <= 1'b0;
        end else begin
            wclk_q  <= dds_wclk;
            hi_cnt  <= dds_wclk ? hi_cnt + 1 : 0;
            stb_cnt <= dds_fqud ? stb_cnt + 1 : 0;
            if (req_valid && req_ready) begin
                bits_since <= '0;
                seen_req   <= 1'b1;
            end else if (dds_wclk && !wclk_q) begin
                bits_since <= bits_since + 1'b1;
            end
        end
    end

    AST_NO_CLK_STB_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(dds_wclk && dds_fqud)); // R6
    AST_DATA_SET_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(dds_wclk) |-> $stable(dds_data)); // R4
    AST_DATA_HELD_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(dds_wclk) |-> $stable(dds_data)); // R4
    AST_CLK_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(dds_wclk) |-> hi_cnt == PHASE_CYC); // R7
    AST_STB_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(dds_fqud) |-> stb_cnt == PHASE_CYC); // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(dds_data || dds_wclk || dds_fqud)); // R9
    AST_BITS_PER_LOAD: assert property (@(posedge clk) disable iff (rst)
        ($rose(dds_fqud) && seen_req) |-> bits_since == 8'(FRAME_W)); // R2
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

bind dds_serial_loader dds_serial_loader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dds_data  (dds_data),
    .dds_wclk  (dds_wclk),
    .dds_fqud  (dds_fqud)
);

// File: tb/dds_serial_loader_tb.sv
module dds_serial_loader_tb;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_word = '0;
    logic        req_mult = 1'b0;
    logic [4:0]  req_phase = '0;
    logic        dds_data, dds_wclk, dds_fqud;

    always #10 clk = ~clk;

    dds_serial_loader #(.PHASE_CYC(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_word  (req_word),
        .req_mult  (req_mult),
        .req_phase (req_phase),
        .dds_data  (dds_data),
        .dds_wclk  (dds_wclk),
        .dds_fqud  (dds_fqud)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // monitor state, sampled on falling clock edges
    logic        pw, pf, dr, busy;
    int          nb, nf, hc, sc;
    int          r4_bad, r6_bad, r7_bad, r8_bad, r9_bad;
    logic [63:0] cur;
    logic [63:0] frm_data [0:15];
    int          frm_bits [0:15];

    always @(negedge clk) begin
        if (rst) begin
            pw = 0; pf = 0; dr = 0; busy = 0;
            nb = 0; nf = 0; hc = 0; sc = 0; cur = '0;
            r4_bad = 0; r6_bad = 0; r7_bad = 0; r8_bad = 0; r9_bad = 0;
        end else begin
            if (dds_wclk && !pw) begin
                if (nb < 64) cur[nb] = dds_data;
                nb++;
                dr = dds_data;
            end
            if (dds_wclk) hc++;
            if (!dds_wclk && pw) begin
                if (hc != N) r7_bad++;
                if (dds_data != dr) r4_bad++;
                hc = 0;
            end
            if (dds_fqud) sc++;
            if (dds_fqud && !pf) begin
                if (dds_wclk || pw) r6_bad++;
                if (nf < 16) begin
                    frm_bits[nf] = nb;
                    frm_data[nf] = cur;
                end
                nf++;
                nb = 0;
                cur = '0;
            end
            if (!dds_fqud && pf) begin
                if (sc != N) r7_bad++;
                sc = 0;
                busy = 0;
            end
            if (req_ready && (dds_data || dds_wclk || dds_fqud)) r9_bad++;
            if (busy && req_ready) r8_bad++;
            if (req_valid && req_ready) busy = 1;
            pw = dds_wclk;
            pf = dds_fqud;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input int frames);
        while (!(nf >= frames && req_ready)) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R1 ready low in entry", 64'(req_ready), 64'd0);
        check({dds_data, dds_wclk, dds_fqud} == 3'b000, "R1 outputs low at entry start",
              64'({dds_data, dds_wclk, dds_fqud}), 64'd0);
        wait_done(1);
        check(nf == 1, "R1 one strobe in entry", 64'(nf), 64'd1);
        check(frm_bits[0] == 1, "R1 one word clock in entry", 64'(frm_bits[0]), 64'd1);
        check(frm_data[0] == 0, "R1 data low in entry", frm_data[0], 64'd0);
        check(r7_bad == 0 && r6_bad == 0, "R7 entry phase lengths",
              64'(r7_bad + r6_bad), 64'd0);
    endtask

    task automatic t_load(input logic [31:0] w, input logic m, input logic [4:0] ph);
        int          base, b4, b6, b7, b8, b9;
        logic [39:0] exp;
        base = nf; b4 = r4_bad; b6 = r6_bad; b7 = r7_bad; b8 = r8_bad; b9 = r9_bad;
        exp = {ph, 2'b00, m, w};
        req_word = w; req_mult = m; req_phase = ph; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(base + 1);
        check(frm_bits[base] == 40, "R2 bits per load", 64'(frm_bits[base]), 64'd40);
        check(frm_data[base][31:0] == w, "R3 word LSB first",
              64'(frm_data[base][31:0]), 64'(w));
        check(frm_data[base][39:32] == exp[39:32], "R5 control byte",
              64'(frm_data[base][39:32]), 64'(exp[39:32]));
        check(r4_bad == b4, "R4 data stable around clock", 64'(r4_bad - b4), 64'd0);
        check(r6_bad == b6, "R6 strobe after last clock", 64'(r6_bad - b6), 64'd0);
        check(r7_bad == b7, "R7 phase lengths", 64'(r7_bad - b7), 64'd0);
        check(r8_bad == b8, "R8 ready low while busy", 64'(r8_bad - b8), 64'd0);
        check(r9_bad == b9, "R9 quiet when idle", 64'(r9_bad - b9), 64'd0);
    endtask

    task automatic t_hold;
        int base;
        base = nf;
        req_word = 32'hDEAD_BEEF; req_mult = 1'b1; req_phase = 5'd9; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // first request accepted; change fields while it is sent, keep valid
        req_word = 32'h0F0F_1234; req_mult = 1'b0; req_phase = 5'd22;
        repeat (20) @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low mid load", 64'(req_ready), 64'd0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(base + 2);
        check(frm_data[base][39:0] == {5'd9, 2'b00, 1'b1, 32'hDEAD_BEEF},
              "R10 first frame unaffected", frm_data[base],
              64'({5'd9, 2'b00, 1'b1, 32'hDEAD_BEEF}));
        check(frm_data[base+1][39:0] == {5'd22, 2'b00, 1'b0, 32'h0F0F_1234},
              "R8 held request sent", frm_data[base+1],
              64'({5'd22, 2'b00, 1'b0, 32'h0F0F_1234}));
        check(frm_bits[base+1] == 40, "R2 bits second load", 64'(frm_bits[base+1]), 64'd40);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_load(32'h0000_0000, 1'b0, 5'd0);
        t_load(32'hFFFF_FFFF, 1'b1, 5'd31);
        t_load(32'hA5C3_1E07, 1'b1, 5'd5);
        t_load(32'h1234_5678, 1'b0, 5'd16);
        t_hold();
        t_reset();
        t_load(32'h8000_0001, 1'b1, 5'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule